// File: doc/BRIEF.md
# Segment lookaside buffer

This block keeps a small, fully associative table of segment descriptors and answers whether an effective address falls inside one of them. Each slot holds two 64-bit words. The first is the effective segment word: the segment number sits in its upper bits and bit 27 is the valid flag. The second is the virtual segment word: a 2-bit size code sits in bits 63:62, and the remaining bits carry keys and flags that the block stores and returns without interpreting them. A slot describes either a 256 MB segment or a 1 TB segment. The lookup compares every slot under the rule that matches that slot's own size code.

A single command port takes one operation per cycle. The operations are lookup, slot write, slot read of either word, invalidate-all and invalidate-by-address. Exactly one registered response appears on the following cycle. The two invalidates can pulse `flush_req`, which tells a downstream translation cache that cached translations are stale.

The response path is a small state machine. The states are RS_IDLE, RS_LOOK, RS_WRITE, RS_READ and RS_INVAL. On every clock edge the state moves to the one that belongs to the command presented in that cycle. A lookup leads to RS_LOOK, a write to RS_WRITE, either read to RS_READ, and either invalidate to RS_INVAL. A no-op or an unused opcode returns the machine to RS_IDLE. `rsp_valid` is high in every state except RS_IDLE.

Top module: `slb_unit`

## Requirements
- R1: After reset every word of every slot is zero. A lookup then misses, and a read of either word of any slot returns 0 without error.
- R2: A slot with size code 00 hits when its segment word equals the address with bits 27:0 cleared and bit 27 then set.
- R3: A slot with size code 01 hits when its segment word equals the address with bits 39:0 cleared and bit 27 then set. A 00-coded slot never hits through this 1 TB key alone.
- R4: When several slots hit, the response names the lowest-numbered one.
- R5: The opcodes on `cmd_op` are 1 lookup, 2 write, 3 read segment word, 4 read virtual word, 5 invalidate-all, 6 invalidate-by-address, and 0 no-op. Each command gives `rsp_valid` exactly one cycle later. A lookup reports hit, slot and both words of the winning slot, and reports zeros on a miss.
- R6: A write takes its slot from `cmd_addr[11:0]`. If that value is not below NUM_SLOTS, the write sets `rsp_err` and changes nothing.
- R7: A write whose `cmd_data[63:62]` is 10 or 11 is rejected with `rsp_err`, as is code 01 when ALLOW_1T is 0. A rejected write leaves the table unchanged.
- R8: An accepted write stores `cmd_addr` masked to bits 63:28 and bit 27 as the segment word, and stores `cmd_data` unchanged as the virtual word.
- R9: A read whose `cmd_addr[11:0]` is not below NUM_SLOTS returns `rsp_err`=1 and `rsp_data`=0. Otherwise it returns the selected word with `rsp_err`=0.
- R10: Invalidate-all clears bit 27 of slots 1 to NUM_SLOTS-1. Slot 0 and all other bits are untouched.
- R11: Invalidate-all pulses `flush_req` with its response only if some slot other than slot 0 was valid just before it.
- R12: Invalidate-by-address performs a lookup and reports it as R5 does. On a hit it clears bit 27 of the winning slot and pulses `flush_req`. On a miss it changes nothing and does not flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 64 | Effective address, or slot index plus segment word for writes |
| cmd_data | input | 64 | Virtual segment word for writes |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | Lookup or invalidate-by-address found a slot |
| rsp_slot | output | $clog2(NUM_SLOTS) | Winning slot index |
| rsp_esid | output | 64 | Segment word of the winning slot |
| rsp_vsid | output | 64 | Virtual word of the winning slot |
| rsp_data | output | 64 | Word returned by a read |
| rsp_err | output | 1 | Write or read rejected |
| flush_req | output | 1 | One-cycle flush request to the translation cache |

## Verification
Lookups are tried against small-segment slots, large-segment slots and duplicated slots. The first two patterns separate a correct per-slot size rule from one that compares both keys regardless of the code. The duplicated pattern exposes a wrong priority order. An address that shares a 1 TB region with a 256 MB slot, but not its 256 MB segment, must miss. Writes carry junk in the index and reserved bits and use every size code, and read-backs of untouched slots show that rejected writes left no trace. Both invalidates are run once when they should flush and once when they should not, including the case where only slot 0 stays valid.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int WORD_W    = 64;
    localparam int VLD_BIT   = 27;
    localparam int SEG_S_LSB = 28;
    localparam int SEG_L_LSB = 40;
    localparam int IDX_W     = 12;
    localparam int SZ_HI     = 63;
    localparam int SZ_LO     = 62;

    localparam logic [1:0] SZ_SMALL = 2'b00;
    localparam logic [1:0] SZ_LARGE = 2'b01;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LOOKUP   = 3'd1,
        OP_WRITE    = 3'd2,
        OP_RD_ESID  = 3'd3,
        OP_RD_VSID  = 3'd4,
        OP_INV_ALL  = 3'd5,
        OP_INV_ADDR = 3'd6
    } slb_op_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_LOOK,
        RS_WRITE,
        RS_READ,
        RS_INVAL
    } rsp_state_e;

    function automatic word_t seg_keep_mask();
        return ({WORD_W{1'b1}} << SEG_S_LSB) | (word_t'(1) << VLD_BIT);
    endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic [WORD_W-1:0]                 probe,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  ent_esid,
    input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  ent_vsid,
    output logic                              hit,
    output logic [SLOT_W-1:0]                 slot,
    output logic [WORD_W-1:0]                 hit_esid,
    output logic [WORD_W-1:0]                 hit_vsid
);
    word_t key_small;
    word_t key_large;
    logic [NUM_SLOTS-1:0] match;

    assign key_small = (probe & ({WORD_W{1'b1}} << SEG_S_LSB)) | (word_t'(1) << VLD_BIT);
    assign key_large = (probe & ({WORD_W{1'b1}} << SEG_L_LSB)) | (word_t'(1) << VLD_BIT);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        logic [1:0] code;
        assign code = ent_vsid[g][SZ_HI:SZ_LO];
        assign match[g] = ((ent_esid[g] == key_small) && (code == SZ_SMALL)) ||
                          ((ent_esid[g] == key_large) && (code == SZ_LARGE));
    end

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit  = 1'b1;
                slot = SLOT_W'(k);
            end
        end
    end

    assign hit_esid = hit ? ent_esid[slot] : '0;
    assign hit_vsid = hit ? ent_vsid[slot] : '0;
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3,
    parameter bit ALLOW_1T  = 1'b1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        size_code,
    output logic              idx_ok,
    output logic              size_ok,
    output logic [SLOT_W-1:0] slot
);
    logic large_ok;

    if (ALLOW_1T) begin : g_large_on
        assign large_ok = 1'b1;
    end else begin : g_large_off
        assign large_ok = 1'b0;
    end

    assign idx_ok  = (int'(idx) < NUM_SLOTS);
    assign size_ok = (size_code == SZ_SMALL) || ((size_code == SZ_LARGE) && large_ok);
    assign slot    = idx[SLOT_W-1:0];
endmodule

// File: rtl/slb_store.sv
module slb_store
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SLOT_W-1:0]                 wr_slot,
    input  logic [WORD_W-1:0]                 wr_esid,
    input  logic [WORD_W-1:0]                 wr_vsid,
    input  logic                              clr_all,
    input  logic                              clr_one,
    input  logic [SLOT_W-1:0]                 clr_slot,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]  ent_esid,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]  ent_vsid
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam bit SWEEPABLE = (g != 0);
        logic sel_wr;
        logic sel_clr;

        assign sel_wr  = wr_en && (wr_slot == SLOT_W'(g));
        assign sel_clr = (clr_one && (clr_slot == SLOT_W'(g))) || (clr_all && SWEEPABLE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_esid[g] <= '0;
                ent_vsid[g] <= '0;
            end else if (sel_wr) begin
                ent_esid[g] <= wr_esid;
                ent_vsid[g] <= wr_vsid;
            end else if (sel_clr) begin
                ent_esid[g][VLD_BIT] <= 1'b0;
            end
        end

        if (SWEEPABLE) begin : g_swept
            // R10
            sweep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_all && !wr_en) |=> !ent_esid[g][VLD_BIT]);
        end else begin : g_kept
            // R10
            slot0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_all && !wr_en && !clr_one) |=> $stable(ent_esid[g]));
        end
    end
endmodule

// File: rtl/slb_unit.sv
module slb_unit
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter bit ALLOW_1T  = 1'b1,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [63:0]       cmd_addr,
    input  logic [63:0]       cmd_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic [63:0]       rsp_esid,
    output logic [63:0]       rsp_vsid,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              flush_req
);
    slb_op_e op;
    assign op = slb_op_e'(cmd_op);

    logic [NUM_SLOTS-1:0][WORD_W-1:0] ent_esid;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] ent_vsid;

    logic              m_hit;
    logic [SLOT_W-1:0] m_slot;
    word_t             m_esid;
    word_t             m_vsid;

    logic              idx_ok;
    logic              size_ok;
    logic [SLOT_W-1:0] ix_slot;

    slb_match #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_match (
        .probe    (cmd_addr),
        .ent_esid (ent_esid),
        .ent_vsid (ent_vsid),
        .hit      (m_hit),
        .slot     (m_slot),
        .hit_esid (m_esid),
        .hit_vsid (m_vsid)
    );

    slb_wr_check #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ALLOW_1T(ALLOW_1T)) u_check (
        .idx       (cmd_addr[IDX_W-1:0]),
        .size_code (cmd_data[SZ_HI:SZ_LO]),
        .idx_ok    (idx_ok),
        .size_ok   (size_ok),
        .slot      (ix_slot)
    );

    logic wr_en;
    logic clr_all;
    logic clr_one;

    assign wr_en   = (op == OP_WRITE) && idx_ok && size_ok;
    assign clr_all = (op == OP_INV_ALL);
    assign clr_one = (op == OP_INV_ADDR) && m_hit;

    slb_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (ix_slot),
        .wr_esid  (cmd_addr & seg_keep_mask()),
        .wr_vsid  (cmd_data),
        .clr_all  (clr_all),
        .clr_one  (clr_one),
        .clr_slot (m_slot),
        .ent_esid (ent_esid),
        .ent_vsid (ent_vsid)
    );

    logic others_valid;
    always_comb begin
        others_valid = 1'b0;
        for (int k = 1; k < NUM_SLOTS; k++) begin
            others_valid = others_valid | ent_esid[k][VLD_BIT];
        end
    end

    word_t rd_word;
    always_comb begin
        rd_word = '0;
        if (idx_ok) begin
            rd_word = (op == OP_RD_VSID) ? ent_vsid[ix_slot] : ent_esid[ix_slot];
        end
    end

    rsp_state_e rsp_state;
    rsp_state_e nxt_state;

    always_comb begin
        unique case (op)
            OP_LOOKUP:              nxt_state = RS_LOOK;
            OP_WRITE:               nxt_state = RS_WRITE;
            OP_RD_ESID, OP_RD_VSID: nxt_state = RS_READ;
            OP_INV_ALL, OP_INV_ADDR: nxt_state = RS_INVAL;
            default:                nxt_state = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_state <= RS_IDLE;
        else        rsp_state <= nxt_state;
    end

    logic              hit_q;
    logic [SLOT_W-1:0] slot_q;
    word_t             esid_q;
    word_t             vsid_q;
    word_t             data_q;
    logic              err_q;
    logic              flush_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            slot_q  <= '0;
            esid_q  <= '0;
            vsid_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            hit_q   <= 1'b0;
            slot_q  <= '0;
            esid_q  <= '0;
            vsid_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            flush_q <= 1'b0;
            case (op)
                OP_LOOKUP, OP_INV_ADDR: begin
                    hit_q   <= m_hit;
                    slot_q  <= m_slot;
                    esid_q  <= m_esid;
                    vsid_q  <= m_vsid;
                    flush_q <= (op == OP_INV_ADDR) && m_hit;
                end
                OP_WRITE: err_q <= !(idx_ok && size_ok);
                OP_RD_ESID, OP_RD_VSID: begin
                    err_q  <= !idx_ok;
                    data_q <= rd_word;
                end
                OP_INV_ALL: flush_q <= others_valid;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rsp_state)
            RS_IDLE:                             rsp_valid = 1'b0;
            RS_LOOK, RS_WRITE, RS_READ, RS_INVAL: rsp_valid = 1'b1;
            default:                             rsp_valid = 1'b0;
        endcase
        rsp_hit   = hit_q;
        rsp_slot  = slot_q;
        rsp_esid  = esid_q;
        rsp_vsid  = vsid_q;
        rsp_data  = data_q;
        rsp_err   = err_q;
        flush_req = flush_q;
    end

    // R11
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (rsp_state == RS_INVAL));

    // R5
    hit_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_state == RS_LOOK || rsp_state == RS_INVAL));

    // R7
    bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && !(idx_ok && size_ok)) |=> ($stable(ent_esid) && $stable(ent_vsid)));

    // R9
    rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_state == RS_READ && rsp_err) |-> (rsp_data == '0));

    // R12
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INV_ADDR && !m_hit) |=> ($stable(ent_esid) && !flush_req));
endmodule

// File: tb/test_slb_unit.sv
module test_slb_unit;
    localparam int N = 8;
    localparam logic [63:0] V    = 64'h0000_0000_0800_0000;
    localparam logic [63:0] KEEP = 64'hFFFF_FFFF_F800_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [63:0] cmd_addr = '0;
    logic [63:0] cmd_data = '0;
    logic        rsp_valid, rsp_hit, rsp_err, flush_req;
    logic [2:0]  rsp_slot;
    logic [63:0] rsp_esid, rsp_vsid, rsp_data;

    logic [2:0]  c2_op = 3'd0;
    logic [63:0] c2_addr = '0;
    logic [63:0] c2_data = '0;
    logic        c2_valid, c2_hit, c2_err, c2_flush;
    logic [1:0]  c2_slot;
    logic [63:0] c2_esid, c2_vsid, c2_rdata;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slb_unit #(.NUM_SLOTS(N), .ALLOW_1T(1'b1)) i_slb_unit (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slot(rsp_slot), .rsp_esid(rsp_esid),
        .rsp_vsid(rsp_vsid), .rsp_data(rsp_data), .rsp_err(rsp_err), .flush_req(flush_req)
    );

    slb_unit #(.NUM_SLOTS(4), .ALLOW_1T(1'b0)) i_slb_unit_small (
        .clk(clk), .rst_n(rst_n), .cmd_op(c2_op), .cmd_addr(c2_addr), .cmd_data(c2_data),
        .rsp_valid(c2_valid), .rsp_hit(c2_hit), .rsp_slot(c2_slot), .rsp_esid(c2_esid),
        .rsp_vsid(c2_vsid), .rsp_data(c2_rdata), .rsp_err(c2_err), .flush_req(c2_flush)
    );

    typedef struct {
        string       tag;
        logic        hit;
        int          slot;
        logic [63:0] esid;
        logic [63:0] vsid;
        logic [63:0] data;
        logic        err;
        logic        flush;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    logic [63:0] me [N];
    logic [63:0] mv [N];

    task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d,
                         input string tag);
        exp_t e;
        int idx;
        int hs;
        logic [63:0] ks, kl;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d;
        e.tag = tag; e.hit = 0; e.slot = 0; e.esid = '0; e.vsid = '0;
        e.data = '0; e.err = 0; e.flush = 0;
        idx = int'(a[11:0]);
        ks = {a[63:28], 28'h0} | V;
        kl = {a[63:40], 40'h0} | V;
        hs = -1;
        for (int k = N - 1; k >= 0; k--) begin
            if ((me[k] == ks && mv[k][63:62] == 2'b00) || (me[k] == kl && mv[k][63:62] == 2'b01))
                hs = k;
        end
        case (op)
            3'd1, 3'd6: begin
                if (hs >= 0) begin
                    e.hit = 1; e.slot = hs; e.esid = me[hs]; e.vsid = mv[hs];
                    if (op == 3'd6) begin
                        e.flush = 1;
                        me[hs][27] = 1'b0;
                    end
                end
            end
            3'd2: begin
                if (idx >= N || d[63]) e.err = 1;
                else begin
                    me[idx] = a & KEEP;
                    mv[idx] = d;
                end
            end
            3'd3, 3'd4: begin
                if (idx >= N) e.err = 1;
                else e.data = (op == 3'd3) ? me[idx] : mv[idx];
            end
            3'd5: begin
                for (int k = 1; k < N; k++) begin
                    if (me[k][27]) e.flush = 1;
                    me[k][27] = 1'b0;
                end
            end
            default: ;
        endcase
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            cur = q.pop_front();
            compared++;
            if (!rsp_valid || rsp_hit !== cur.hit || int'(rsp_slot) != cur.slot ||
                rsp_esid !== cur.esid || rsp_vsid !== cur.vsid || rsp_data !== cur.data ||
                rsp_err !== cur.err || flush_req !== cur.flush) begin
                mismatched++;
                $display("FAIL %s: got v=%0b hit=%0b slot=%0d esid=%h vsid=%h data=%h err=%0b flush=%0b; want v=1 hit=%0b slot=%0d esid=%h vsid=%h data=%h err=%0b flush=%0b",
                         cur.tag, rsp_valid, rsp_hit, rsp_slot, rsp_esid, rsp_vsid, rsp_data,
                         rsp_err, flush_req, cur.hit, cur.slot, cur.esid, cur.vsid, cur.data,
                         cur.err, cur.flush);
            end
        end else if (rst_n && (rsp_valid || flush_req)) begin
            compared++;
            mismatched++;
            $display("FAIL R5: unexpected response valid=%0b flush=%0b, want none", rsp_valid, flush_req);
        end
    end

    task automatic chk2(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d,
                        input logic want_err, input logic [63:0] want_data, input string tag);
        @(negedge clk);
        c2_op = op; c2_addr = a; c2_data = d;
        @(posedge clk);
        #2;
        compared++;
        if (!c2_valid || c2_err !== want_err || c2_rdata !== want_data) begin
            mismatched++;
            $display("FAIL %s: got v=%0b err=%0b data=%h; want v=1 err=%0b data=%h",
                     tag, c2_valid, c2_err, c2_rdata, want_err, want_data);
        end
        @(negedge clk);
        c2_op = 3'd0;
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            me[k] = '0;
            mv[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compared++;
        if (rsp_valid !== 1'b0 || flush_req !== 1'b0 || rsp_err !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: reset outputs valid=%0b flush=%0b err=%0b, want 0 0 0",
                     rsp_valid, flush_req, rsp_err);
        end
        // R1 empty table
        issue(3'd1, 64'h0, 64'h0, "R1");
        issue(3'd3, 64'h0, 64'h0, "R1");
        issue(3'd4, 64'h7, 64'h0, "R1");
        // R8 / R2 small segment in slot 0
        issue(3'd2, 64'h0000_0001_2000_0000 | V, 64'h0000_0000_0ABC_D000, "R8");
        issue(3'd1, 64'h0000_0001_2345_6789, 64'h0, "R2");
        issue(3'd1, 64'h0000_0001_3000_0000, 64'h0, "R2");
        // R8 / R3 large segment in slot 3, junk bits masked
        issue(3'd2, 64'h0000_0500_0000_0000 | V | 64'h0010_0003, 64'h4000_0000_0000_0777, "R8");
        issue(3'd3, 64'h3, 64'h0, "R8");
        issue(3'd4, 64'h3, 64'h0, "R8");
        issue(3'd1, 64'h0000_05AB_CDEF_0123, 64'h0, "R3");
        // R3 small slot must not hit through the large key
        issue(3'd2, 64'h0000_0700_0000_0000 | V | 64'h1, 64'h0000_0000_0000_0111, "R3");
        issue(3'd1, 64'h0000_0700_1000_0000, 64'h0, "R3");
        issue(3'd1, 64'h0000_0700_0FFF_FFFF, 64'h0, "R2");
        // R4 duplicates
        issue(3'd2, 64'h0000_0001_2000_0000 | V | 64'h5, 64'h0000_0000_0000_0555, "R4");
        issue(3'd2, 64'h0000_0001_2000_0000 | V | 64'h2, 64'h0000_0000_0000_0222, "R4");
        issue(3'd1, 64'h0000_0001_2000_0040, 64'h0, "R4");
        // R6 / R7 rejected writes
        issue(3'd2, 64'h0000_0009_0000_0000 | V | 64'h8, 64'h0, "R6");
        issue(3'd2, 64'h0000_0009_0000_0000 | V | 64'h800, 64'h0, "R6");
        issue(3'd2, 64'h0000_0009_0000_0000 | V | 64'h4, 64'h8000_0000_0000_0000, "R7");
        issue(3'd2, 64'h0000_0009_0000_0000 | V | 64'h4, 64'hC000_0000_0000_0000, "R7");
        issue(3'd3, 64'h4, 64'h0, "R7");
        issue(3'd1, 64'h0000_0009_0000_0000, 64'h0, "R6");
        // R9 read errors
        issue(3'd3, 64'h8, 64'h0, "R9");
        issue(3'd4, 64'hFFF, 64'h0, "R9");
        // R12 invalidate by address
        issue(3'd6, 64'h0000_0001_2345_0000, 64'h0, "R12");
        issue(3'd1, 64'h0000_0001_2345_0000, 64'h0, "R12");
        issue(3'd3, 64'h0, 64'h0, "R12");
        issue(3'd6, 64'h0000_0009_0000_0000, 64'h0, "R12");
        // R10 / R11 invalidate all
        issue(3'd2, 64'h0000_0001_2000_0000 | V, 64'h0000_0000_0ABC_D000, "R10");
        issue(3'd5, 64'h0, 64'h0, "R11");
        issue(3'd1, 64'h0000_0001_2345_0000, 64'h0, "R10");
        issue(3'd1, 64'h0000_05AB_CDEF_0123, 64'h0, "R10");
        issue(3'd3, 64'h3, 64'h0, "R10");
        issue(3'd5, 64'h0, 64'h0, "R11");
        @(negedge clk);
        cmd_op = 3'd0;
        repeat (2) @(posedge clk);
        // R7 / R6 on the instance without large segments, four slots
        chk2(3'd2, 64'h0000_0500_0000_0000 | V | 64'h1, 64'h4000_0000_0000_0001, 1'b1, 64'h0, "R7");
        chk2(3'd3, 64'h1, 64'h0, 1'b0, 64'h0, "R7");
        chk2(3'd2, 64'h0000_0500_0000_0000 | V | 64'h1, 64'h0000_0000_0000_0001, 1'b0, 64'h0, "R7");
        chk2(3'd3, 64'h1, 64'h0, 1'b0, 64'h0000_0500_0800_0000, "R8");
        chk2(3'd2, 64'h0000_0500_0000_0000 | V | 64'h4, 64'h0, 1'b1, 64'h0, "R6");
        chk2(3'd4, 64'h4, 64'h0, 1'b1, 64'h0, "R9");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, got hung, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule